// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block sits behind a serial memory front end and turns a write session into a timed commit of a byte-addressed non-volatile array. The front end hands it decoded events: the start of a write (with the 16-bit start address that followed the opcode), each complete received data byte together with a per-address write-permitted flag, and the chip-select rise that closes the session. Bytes are staged in a 64-entry page buffer. The page part of the address is held for the whole session, and only the byte-within-page index advances. When the index runs past the end of the page it wraps to offset 0 of the same page.

When chip select rises on a session that received only whole bytes and at least one permitted byte, the block enters a self-timed program cycle of `WC_CYCLES` system clocks. During this cycle it reports busy. In the first cycles of the program cycle it streams each staged byte into the array model through a simple write strobe, in ascending offset order. When the cycle ends it pulses a request to clear the write-enable latch. While busy it ignores every session event, so the front end can keep answering status reads without disturbing the commit.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset `busy`, `wel_clr` and `mem_we` are 0 and `next_addr` is 0.
- R2: A `wr_start` pulse while idle keeps only the low 13 bits of `start_addr`. From the next cycle, `next_addr` equals `start_addr[12:0]`, and bits 15:13 have no effect.
- R3: Each accepted byte advances `next_addr[5:0]` by one, modulo 64. `next_addr[12:6]` (the page) stays unchanged.
- R4: When a session sends more bytes than remain in the page, loading wraps to offset 0 of the same page, and a later byte replaces an earlier one at the same offset.
- R5: A program cycle starts only on `cs_rise` during an open session. `busy` rises in the cycle after that `cs_rise`. A `cs_rise` with no open session does nothing.
- R6: `busy` stays 1 for exactly `WC_CYCLES` consecutive cycles.
- R7: `wel_clr` is a one-cycle pulse in the first cycle after `busy` falls, and it appears only then.
- R8: In program cycle k (k = 0 to 63, counted from the first busy cycle), `mem_we` is 1 exactly when offset k was loaded with permission. In that cycle `mem_addr` = {page, k} and `mem_wdata` is the last byte loaded at offset k. Unloaded offsets are never written.
- R9: A `cs_rise` with `cs_partial`=1 (an incomplete byte was received) discards the session, and no program cycle starts.
- R10: While `busy` is 1, `wr_start`, `byte_valid` and `cs_rise` are ignored. `next_addr` does not change and no further program cycle follows.
- R11: A byte presented in the same cycle as the closing `cs_rise` is included in the commit.
- R12: A byte accepted with `wr_perm`=0 still advances the index but is not written. It also cancels an earlier permitted byte at that offset. A session with no permitted byte starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Write opcode and start address received |
| start_addr | input | 16 | Received start address |
| byte_valid | input | 1 | One complete data byte received |
| byte_data | input | 8 | The received data byte |
| wr_perm | input | 1 | Write permitted at `next_addr` (valid with `byte_valid`) |
| cs_rise | input | 1 | Chip select went inactive |
| cs_partial | input | 1 | A partial byte was in flight at `cs_rise` |
| next_addr | output | 13 | Array address the next byte will load to |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Clear write-enable latch request |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two functions can coincide in one cycle. The first is the arrival of the last data byte and the chip-select rise that closes the session. The bench drives `byte_valid` and `cs_rise` together, and judges the result by whether that byte's offset receives a write strobe with its data during the program cycle. The second is the end of one program cycle meeting the next session's events. The bench sends a full session while busy and expects the staged page, address and cycle count to be untouched. A behavioural model compares every output on every clock.

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int WC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [15:0]       start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              wr_perm,
  input  logic              cs_rise,
  input  logic              cs_partial,
  output logic [ADDR_W-1:0] next_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int NBYTES = 1 << PAGE_W;
  localparam int CNT_W  = (WC_CYCLES > 2) ? $clog2(WC_CYCLES) : 1;

  logic                     sess;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic [PAGE_W-1:0]        ptr;
  logic [7:0]               pbuf [NBYTES];
  logic [NBYTES-1:0]        ld;
  logic [CNT_W-1:0]         cnt;
  logic [PAGE_W:0]          walk;

  wire idle  = ~busy;
  wire open_ = idle & wr_start;
  wire take  = idle & ~wr_start & sess & byte_valid;
  wire any   = (|ld) | (take & wr_perm);
  wire go    = idle & ~wr_start & sess & cs_rise & ~cs_partial & any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sess <= 1'b0;
      page <= '0;
      ptr  <= '0;
      ld   <= '0;
    end else if (open_) begin
      sess <= 1'b1;
      page <= start_addr[ADDR_W-1:PAGE_W];
      ptr  <= start_addr[PAGE_W-1:0];
      ld   <= '0;
    end else if (idle) begin
      if (take) begin
        ld[ptr] <= wr_perm;
        ptr     <= ptr + 1'b1;
      end
      if (cs_rise) sess <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[ptr] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wel_clr <= 1'b0;
      cnt     <= '0;
      walk    <= '0;
    end else begin
      wel_clr <= busy && (cnt == '0);
      if (go) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WC_CYCLES - 1);
        walk <= '0;
      end else if (busy) begin
        if (!walk[PAGE_W]) walk <= walk + 1'b1;
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign next_addr = {page, ptr};
  assign mem_we    = busy & ~walk[PAGE_W] & ld[walk[PAGE_W-1:0]];
  assign mem_addr  = {page, walk[PAGE_W-1:0]};
  assign mem_wdata = pbuf[walk[PAGE_W-1:0]];
endmodule

module page_write_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_start,
  input logic              byte_valid,
  input logic              cs_rise,
  input logic              cs_partial,
  input logic              busy,
  input logic              wel_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] next_addr,
  input logic [ADDR_W-1:0] mem_addr
);
  p_start_on_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise) && !$past(cs_partial));

  p_wel_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $fell(busy));

  p_we_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_page_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !wr_start |=> next_addr[ADDR_W-1:PAGE_W] == $past(next_addr[ADDR_W-1:PAGE_W]));

  p_partial_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && cs_partial && !busy |=> !busy);

  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(next_addr));

  p_we_same_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:PAGE_W] == next_addr[ADDR_W-1:PAGE_W]);
endmodule

bind page_write_ctrl page_write_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb_top;
  localparam int WC = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_start = 0, byte_valid = 0, wr_perm = 0, cs_rise = 0, cs_partial = 0;
  logic [15:0] start_addr = '0;
  logic [7:0]  byte_data = '0;
  logic [12:0] next_addr, mem_addr;
  logic        busy, wel_clr, mem_we;
  logic [7:0]  mem_wdata;

  always #5 clk = ~clk;

  page_write_ctrl #(.WC_CYCLES(WC)) dut_i (.*);

  int errors = 0, checks = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit       m_sess, m_busy, m_done;
  int       m_page, m_ptr, m_cnt, m_walk;
  bit [7:0] m_buf [64];
  bit       m_ld  [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sess = 0; m_busy = 0; m_done = 0; m_page = 0; m_ptr = 0; m_cnt = 0; m_walk = 0;
      foreach (m_ld[i]) m_ld[i] = 0;
    end else begin
      bit was_busy, any;
      was_busy = m_busy;
      m_done = 0;
      if (was_busy) begin
        m_cnt++;
        m_walk++;
        if (m_cnt == WC) begin m_busy = 0; m_done = 1; end
      end else if (wr_start) begin
        m_sess = 1; m_page = start_addr[12:6]; m_ptr = start_addr[5:0];
        foreach (m_ld[i]) m_ld[i] = 0;
      end else if (m_sess) begin
        if (byte_valid) begin
          m_buf[m_ptr] = byte_data; m_ld[m_ptr] = wr_perm; m_ptr = (m_ptr + 1) % 64;
        end
        if (cs_rise) begin
          m_sess = 0;
          any = 0;
          foreach (m_ld[i]) any |= m_ld[i];
          if (!cs_partial && any) begin m_busy = 1; m_cnt = 0; m_walk = 0; end
        end
      end
    end
  end

  logic [7:0] obs [int];
  int blen, wcnt, nwr;

  always @(negedge clk) if (rst_n) begin
    bit e_we;
    e_we = m_busy && m_walk < 64 && m_ld[m_walk % 64];
    chk("R6 busy", busy, m_busy);
    chk("R7 wel_clr", wel_clr, m_done);
    chk("R3 next_addr", next_addr, (m_page << 6) | m_ptr);
    chk("R8 mem_we", mem_we, e_we);
    if (e_we) begin
      chk("R8 mem_addr", mem_addr, (m_page << 6) | m_walk);
      chk("R8 mem_wdata", mem_wdata, m_buf[m_walk]);
    end
    if (busy) blen++;
    if (wel_clr) wcnt++;
    if (mem_we) begin obs[mem_addr] = mem_wdata; nwr++; end
  end

  task automatic drive(bit ws, bit [15:0] a, bit bv, bit [7:0] d, bit p, bit cr, bit cp);
    @(negedge clk);
    wr_start = ws; start_addr = a; byte_valid = bv; byte_data = d;
    wr_perm = p; cs_rise = cr; cs_partial = cp;
  endtask
  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic clr();
    obs.delete(); blen = 0; wcnt = 0; nwr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 wel_clr", wel_clr, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 next_addr", next_addr, 0);
    rst_n = 1;

    // R2 simple write with don't-care high bits
    clr();
    drive(1, 16'hE123, 0, 0, 0, 0, 0);
    idle(1);
    chk("R2 next_addr", next_addr, 13'h0123);
    drive(0, 0, 1, 8'hA1, 1, 0, 0);
    drive(0, 0, 1, 8'hA2, 1, 0, 0);
    drive(0, 0, 1, 8'hA3, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(WC + 10);
    chk("R8 byte0", obs.exists(13'h0123) ? obs[13'h0123] : -1, 8'hA1);
    chk("R8 byte2", obs.exists(13'h0125) ? obs[13'h0125] : -1, 8'hA3);
    chk("R8 count", nwr, 3);
    chk("R6 length", blen, WC);
    chk("R7 pulses", wcnt, 1);

    // R4 wrap within page: 66 bytes from offset 60 of page 5
    clr();
    drive(1, 16'h017C, 0, 0, 0, 0, 0);
    for (int i = 0; i < 66; i++) drive(0, 0, 1, 8'(i + 8'h10), 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(WC + 10);
    chk("R4 off60", obs.exists(13'h017C) ? obs[13'h017C] : -1, 8'h50);
    chk("R4 off62", obs.exists(13'h017E) ? obs[13'h017E] : -1, 8'h12);
    chk("R4 off0", obs.exists(13'h0140) ? obs[13'h0140] : -1, 8'h14);
    chk("R4 count", nwr, 64);

    // R9 partial byte discards
    clr();
    drive(1, 16'h0200, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h77, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 1);
    idle(WC + 5);
    chk("R9 no busy", blen, 0);
    chk("R9 no write", nwr, 0);

    // R5 cs_rise with no session
    clr();
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(5);
    chk("R5 no busy", blen, 0);

    // R11 byte and cs_rise together; R10 session during busy ignored
    clr();
    drive(1, 16'h0300, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'hC0, 1, 0, 0);
    drive(0, 0, 1, 8'hC1, 1, 1, 0);
    idle(3);
    drive(1, 16'h0400, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'hEE, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R10 next_addr", next_addr, 13'h0302);
    idle(WC + 10);
    chk("R11 last byte", obs.exists(13'h0301) ? obs[13'h0301] : -1, 8'hC1);
    chk("R10 single cycle", blen, WC);
    chk("R10 no stray write", obs.exists(13'h0400), 0);

    // R12 permission
    clr();
    drive(1, 16'h0500, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h01, 1, 0, 0);
    drive(0, 0, 1, 8'h02, 0, 0, 0);
    drive(0, 0, 1, 8'h03, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(WC + 10);
    chk("R12 blocked", obs.exists(13'h0501), 0);
    chk("R12 allowed", obs.exists(13'h0502) ? obs[13'h0502] : -1, 8'h03);
    clr();
    drive(1, 16'h0600, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h09, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(10);
    chk("R12 none permitted", blen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule